// File: doc/BRIEF.md
# Endian-Selectable Word-Access Endpoint FIFO

This block holds the packet data of one USB endpoint in two byte-wide FIFOs. The receive FIFO is loaded by the bus side and drained by the CPU or DMA port. The transmit FIFO is loaded by the CPU or DMA port and drained by the bus side. On each access the CPU-side port chooses a size. A byte access moves one byte. A word access moves two bytes in one cycle.

Two global bits set the byte order of word accesses. One bit applies to reads and the other to writes. In big-endian order a word behaves exactly like two byte accesses, high byte first. In little-endian order the low byte goes first.

A simple per-byte interface with a last-byte marker and a corrupt-packet marker stands in for the bus side. The block keeps three sticky status bits, each cleared by write-one-to-clear:
- an overrun bit for discarded packet data;
- a data-error bit for stored corrupt packets;
- an underflow bit for reads that asked for more bytes than were held.

It also keeps a stall indication that an isochronous endpoint never shows.

Top module: `ep_word_fifo`

## Requirements
- R1: After reset both FIFOs are empty: counts are 0 and free space equals DEPTH. The overrun, data-error, underflow and stall outputs are all 0.
- R2: Byte accesses keep FIFO order in both directions. A byte read returns the popped byte on cpu_rdata_o[7:0], with cpu_rdata_o[15:8] = 0.
- R3: With cfg_wr_le_i = 1, a word write pushes cpu_wdata_i[7:0] first and cpu_wdata_i[15:8] second.
- R4: With cfg_wr_le_i = 0, a word write pushes cpu_wdata_i[15:8] first. The resulting byte sequence is identical to two byte writes of the high byte then the low byte.
- R5: With cfg_rd_le_i = 1, a word read holding at least two bytes pops two bytes and returns the first-popped byte on cpu_rdata_o[7:0].
- R6: With cfg_rd_le_i = 0, a word read holding at least two bytes returns the first-popped byte on cpu_rdata_o[15:8].
- R7: rx_count_o and tx_count_o give the bytes stored, one cycle after the access. rx_free_o and tx_free_o give DEPTH minus that count.
- R8: A packet whose first byte arrives while the receive FIFO is not empty is discarded whole, and ovr_o is set. A byte of an accepted packet that arrives while the FIFO is full is discarded, and ovr_o is set.
- R9: sts_clr_i is write-one-to-clear: bit 0 clears ovr_o, bit 1 clears derr_o and bit 2 clears unf_o. A set condition in the same cycle wins over the clear, and clear bits that are 0 leave the other flags as they are.
- R10: An accepted packet whose last byte carries bus_rx_err_i = 1 is still stored in full, and derr_o is set.
- R11: A word read with one byte left pops that byte and places it in the first-order half; the other half reads 0. A read of an empty FIFO pops nothing and returns 0. Both set unf_o.
- R12: stall_req_i sets stall_o and stall_clr_i clears it. While cfg_iso_i = 1, stall_o stays 0 and stall_req_i has no effect.
- R13: A CPU write that does not fit in the transmit FIFO is discarded whole. This covers a word write with one byte free and a byte write with none, and tx_count_o stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_rd_le_i | input | 1 | Word read order: 1 little-endian, 0 big-endian |
| cfg_wr_le_i | input | 1 | Word write order: 1 little-endian, 0 big-endian |
| cfg_iso_i | input | 1 | Endpoint is isochronous |
| cpu_wr_i | input | 1 | CPU write strobe to the transmit FIFO |
| cpu_wr_word_i | input | 1 | Write size: 1 word, 0 byte |
| cpu_wdata_i | input | 16 | Write data (a byte write uses [7:0]) |
| cpu_rd_i | input | 1 | CPU read strobe from the receive FIFO |
| cpu_rd_word_i | input | 1 | Read size: 1 word, 0 byte |
| cpu_rdata_o | output | 16 | Read data, valid in the cycle of cpu_rd_i |
| sts_clr_i | input | 3 | Write-one-to-clear: [0] overrun, [1] data error, [2] underflow |
| ovr_o | output | 1 | Sticky overrun |
| derr_o | output | 1 | Sticky data error |
| unf_o | output | 1 | Sticky read underflow |
| stall_req_i | input | 1 | Request stall |
| stall_clr_i | input | 1 | Release stall |
| stall_o | output | 1 | Stall indication |
| bus_rx_valid_i | input | 1 | Received byte valid |
| bus_rx_data_i | input | 8 | Received byte |
| bus_rx_last_i | input | 1 | Last byte of packet |
| bus_rx_err_i | input | 1 | Packet corrupt, qualified by last |
| bus_tx_rd_i | input | 1 | Bus side pops one transmit byte |
| bus_tx_data_o | output | 8 | Transmit FIFO head byte |
| rx_count_o | output | $clog2(DEPTH+1) | Receive bytes stored |
| rx_free_o | output | $clog2(DEPTH+1) | Receive bytes free |
| tx_count_o | output | $clog2(DEPTH+1) | Transmit bytes stored |
| tx_free_o | output | $clog2(DEPTH+1) | Transmit bytes free |

## Verification
The hardest case to reach is an accepted packet that outgrows the receive FIFO partway through. This is the second overrun path. It only occurs when a packet starts into an empty FIFO and more than DEPTH bytes follow before the CPU reads. The bench sends a DEPTH+1 byte packet of counting data and then drains it with big-endian word reads, so the scoreboard shows that exactly the first DEPTH bytes survived. Word underflow is reached with an odd-length packet read out with word reads only, under both byte orders.

// File: rtl/ep_word_fifo_pkg.sv
package ep_word_fifo_pkg;
  localparam int unsigned CLR_OVR  = 0;
  localparam int unsigned CLR_DERR = 1;
  localparam int unsigned CLR_UNF  = 2;

  typedef enum logic [1:0] {
    AVAIL_NONE = 2'd0,
    AVAIL_ONE  = 2'd1,
    AVAIL_TWO  = 2'd2
  } avail_e;
endpackage

// File: rtl/ep_byte_fifo.sv
// Byte FIFO with up to two pushes and two pops per cycle; DEPTH power of two.
module ep_byte_fifo #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    push_n_i,
  input  logic [7:0]    push_d0_i,
  input  logic [7:0]    push_d1_i,
  input  logic [1:0]    pop_n_i,
  output logic [7:0]    head0_o,
  output logic [7:0]    head1_o,
  output logic [CW-1:0] count_o
);
  logic [7:0]    mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_n_i != 2'd0) mem_q[wp_q] <= push_d0_i;
    if (push_n_i == 2'd2) mem_q[wp_q + AW'(1)] <= push_d1_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_q + AW'(push_n_i);
      rp_q  <= rp_q + AW'(pop_n_i);
      cnt_q <= cnt_q + CW'(push_n_i) - CW'(pop_n_i);
    end
  end

  assign head0_o = mem_q[rp_q];
  assign head1_o = mem_q[rp_q + AW'(1)];
  assign count_o = cnt_q;
endmodule

// File: rtl/ep_word_order.sv
// Splits write words and joins read words according to the byte-order bits.
module ep_word_order
  import ep_word_fifo_pkg::*;
(
  input  logic        wr_le_i,
  input  logic        wr_word_i,
  input  logic [15:0] wdata_i,
  output logic [7:0]  wr_first_o,
  output logic [7:0]  wr_second_o,
  input  logic        rd_le_i,
  input  logic        rd_word_i,
  input  avail_e      rd_avail_i,
  input  logic [7:0]  q0_i,
  input  logic [7:0]  q1_i,
  output logic [15:0] rdata_o
);
  always_comb begin
    if (wr_word_i && !wr_le_i) begin
      wr_first_o  = wdata_i[15:8];
      wr_second_o = wdata_i[7:0];
    end else begin
      wr_first_o  = wdata_i[7:0];
      wr_second_o = wdata_i[15:8];
    end
  end

  logic [7:0] second_b;
  assign second_b = (rd_avail_i == AVAIL_TWO) ? q1_i : 8'h00;

  always_comb begin
    if (rd_avail_i == AVAIL_NONE) rdata_o = 16'h0000;
    else if (!rd_word_i)          rdata_o = {8'h00, q0_i};
    else if (rd_le_i)             rdata_o = {second_b, q0_i};
    else                          rdata_o = {q0_i, second_b};
  end
endmodule

// File: rtl/ep_word_fifo.sv
module ep_word_fifo
  import ep_word_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_rd_le_i,
  input  logic          cfg_wr_le_i,
  input  logic          cfg_iso_i,
  input  logic          cpu_wr_i,
  input  logic          cpu_wr_word_i,
  input  logic [15:0]   cpu_wdata_i,
  input  logic          cpu_rd_i,
  input  logic          cpu_rd_word_i,
  output logic [15:0]   cpu_rdata_o,
  input  logic [2:0]    sts_clr_i,
  output logic          ovr_o,
  output logic          derr_o,
  output logic          unf_o,
  input  logic          stall_req_i,
  input  logic          stall_clr_i,
  output logic          stall_o,
  input  logic          bus_rx_valid_i,
  input  logic [7:0]    bus_rx_data_i,
  input  logic          bus_rx_last_i,
  input  logic          bus_rx_err_i,
  input  logic          bus_tx_rd_i,
  output logic [7:0]    bus_tx_data_o,
  output logic [CW-1:0] rx_count_o,
  output logic [CW-1:0] rx_free_o,
  output logic [CW-1:0] tx_count_o,
  output logic [CW-1:0] tx_free_o
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  // ---------------- receive path ----------------
  logic [7:0]    rx_q0, rx_q1;
  logic [CW-1:0] rx_cnt;
  logic [1:0]    rx_push_n, rx_pop_n;
  avail_e        rx_avail;
  logic          in_pkt_q, drop_q;
  logic          pkt_start, pkt_drop, byte_lost;

  assign rx_avail  = (rx_cnt == '0) ? AVAIL_NONE :
                     (rx_cnt == CW'(1)) ? AVAIL_ONE : AVAIL_TWO;
  assign pkt_start = bus_rx_valid_i && !in_pkt_q;
  assign pkt_drop  = pkt_start ? (rx_cnt != '0) : drop_q;
  assign byte_lost = bus_rx_valid_i && !pkt_drop && (rx_cnt == FULL);
  assign rx_push_n = (bus_rx_valid_i && !pkt_drop && !byte_lost) ? 2'd1 : 2'd0;

  always_comb begin
    rx_pop_n = 2'd0;
    if (cpu_rd_i && rx_avail != AVAIL_NONE)
      rx_pop_n = (cpu_rd_word_i && rx_avail == AVAIL_TWO) ? 2'd2 : 2'd1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_pkt_q <= 1'b0;
      drop_q   <= 1'b0;
    end else if (bus_rx_valid_i) begin
      in_pkt_q <= !bus_rx_last_i;
      drop_q   <= pkt_drop;
    end
  end

  ep_byte_fifo #(.DEPTH(DEPTH)) u_rx_fifo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_n_i (rx_push_n),
    .push_d0_i(bus_rx_data_i),
    .push_d1_i(8'h00),
    .pop_n_i  (rx_pop_n),
    .head0_o  (rx_q0),
    .head1_o  (rx_q1),
    .count_o  (rx_cnt)
  );

  // ---------------- transmit path ----------------
  logic [7:0]    tx_q0, tx_q1, wr_b0, wr_b1;
  logic [CW-1:0] tx_cnt, tx_room;
  logic [1:0]    tx_push_n, tx_pop_n;

  assign tx_room  = FULL - tx_cnt;
  assign tx_pop_n = (bus_tx_rd_i && tx_cnt != '0) ? 2'd1 : 2'd0;

  always_comb begin
    tx_push_n = 2'd0;
    if (cpu_wr_i) begin
      if (cpu_wr_word_i) tx_push_n = (tx_room >= CW'(2)) ? 2'd2 : 2'd0;
      else               tx_push_n = (tx_room != '0) ? 2'd1 : 2'd0;
    end
  end

  ep_byte_fifo #(.DEPTH(DEPTH)) u_tx_fifo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_n_i (tx_push_n),
    .push_d0_i(wr_b0),
    .push_d1_i(wr_b1),
    .pop_n_i  (tx_pop_n),
    .head0_o  (tx_q0),
    .head1_o  (tx_q1),
    .count_o  (tx_cnt)
  );

  ep_word_order u_order (
    .wr_le_i    (cfg_wr_le_i),
    .wr_word_i  (cpu_wr_word_i),
    .wdata_i    (cpu_wdata_i),
    .wr_first_o (wr_b0),
    .wr_second_o(wr_b1),
    .rd_le_i    (cfg_rd_le_i),
    .rd_word_i  (cpu_rd_word_i),
    .rd_avail_i (rx_avail),
    .q0_i       (rx_q0),
    .q1_i       (rx_q1),
    .rdata_o    (cpu_rdata_o)
  );

  // ---------------- status ----------------
  logic ovr_q, derr_q, unf_q, stall_q;
  logic ovr_set, derr_set, unf_set;

  assign ovr_set  = (pkt_start && pkt_drop) || byte_lost;
  assign derr_set = bus_rx_valid_i && bus_rx_last_i && bus_rx_err_i && !pkt_drop;
  assign unf_set  = cpu_rd_i && ((rx_avail == AVAIL_NONE) ||
                                 (cpu_rd_word_i && rx_avail == AVAIL_ONE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_q   <= 1'b0;
      derr_q  <= 1'b0;
      unf_q   <= 1'b0;
      stall_q <= 1'b0;
    end else begin
      ovr_q   <= ovr_set  || (ovr_q  && !sts_clr_i[CLR_OVR]);
      derr_q  <= derr_set || (derr_q && !sts_clr_i[CLR_DERR]);
      unf_q   <= unf_set  || (unf_q  && !sts_clr_i[CLR_UNF]);
      if (cfg_iso_i || stall_clr_i) stall_q <= 1'b0;
      else if (stall_req_i)         stall_q <= 1'b1;
    end
  end

  assign ovr_o         = ovr_q;
  assign derr_o        = derr_q;
  assign unf_o         = unf_q;
  assign stall_o       = stall_q && !cfg_iso_i;
  assign bus_tx_data_o = tx_q0;
  assign rx_count_o    = rx_cnt;
  assign rx_free_o     = FULL - rx_cnt;
  assign tx_count_o    = tx_cnt;
  assign tx_free_o     = tx_room;

  logic unused_tx_q1;
  assign unused_tx_q1 = ^tx_q1;
endmodule

// File: rtl/ep_word_fifo_chk.sv
module ep_word_fifo_chk #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cfg_iso_i,
  input logic          cpu_wr_i,
  input logic          cpu_rd_i,
  input logic          cpu_rd_word_i,
  input logic [2:0]    sts_clr_i,
  input logic          ovr_o,
  input logic          derr_o,
  input logic          unf_o,
  input logic          stall_o,
  input logic          bus_rx_valid_i,
  input logic          bus_rx_last_i,
  input logic          bus_rx_err_i,
  input logic          bus_tx_rd_i,
  input logic          in_pkt_i,
  input logic [CW-1:0] rx_count_o,
  input logic [CW-1:0] tx_count_o
);
  assert_iso_no_stall_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_iso_i |-> !stall_o);

  assert_busy_start_overrun_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rx_valid_i && !in_pkt_i && rx_count_o != '0 |=> ovr_o);

  assert_ovr_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o && !sts_clr_i[0] |=> ovr_o);

  assert_derr_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(derr_o) |-> $past(bus_rx_valid_i && bus_rx_last_i && bus_rx_err_i));

  assert_word_pop_two_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rd_i && cpu_rd_word_i && rx_count_o >= CW'(2) && !bus_rx_valid_i
    |=> rx_count_o == CW'($past(rx_count_o) - CW'(2)));

  assert_empty_read_unf_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rd_i && rx_count_o == '0 |=> unf_o);

  assert_full_write_dropped_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_wr_i && !bus_tx_rd_i && tx_count_o == CW'(DEPTH) |=> tx_count_o == CW'(DEPTH));
endmodule

bind ep_word_fifo ep_word_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cfg_iso_i     (cfg_iso_i),
  .cpu_wr_i      (cpu_wr_i),
  .cpu_rd_i      (cpu_rd_i),
  .cpu_rd_word_i (cpu_rd_word_i),
  .sts_clr_i     (sts_clr_i),
  .ovr_o         (ovr_o),
  .derr_o        (derr_o),
  .unf_o         (unf_o),
  .stall_o       (stall_o),
  .bus_rx_valid_i(bus_rx_valid_i),
  .bus_rx_last_i (bus_rx_last_i),
  .bus_rx_err_i  (bus_rx_err_i),
  .bus_tx_rd_i   (bus_tx_rd_i),
  .in_pkt_i      (in_pkt_q),
  .rx_count_o    (rx_count_o),
  .tx_count_o    (tx_count_o)
);

// File: tb/tb_ep_word_fifo.sv
`timescale 1ns/1ps
module tb_ep_word_fifo;
  localparam int DEPTH = 64;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic cfg_rd_le = 0, cfg_wr_le = 0, cfg_iso = 0;
  logic cpu_wr = 0, cpu_wr_word = 0, cpu_rd = 0, cpu_rd_word = 0;
  logic [15:0] cpu_wdata = '0, cpu_rdata;
  logic [2:0] sts_clr = '0;
  logic ovr, derr, unf, stall_req = 0, stall_clr = 0, stall;
  logic rx_valid = 0, rx_last = 0, rx_err = 0, tx_rd = 0;
  logic [7:0] rx_data = '0, tx_data;
  logic [CW-1:0] rx_count, rx_free, tx_count, tx_free;

  ep_word_fifo #(.DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_rd_le_i(cfg_rd_le), .cfg_wr_le_i(cfg_wr_le), .cfg_iso_i(cfg_iso),
    .cpu_wr_i(cpu_wr), .cpu_wr_word_i(cpu_wr_word), .cpu_wdata_i(cpu_wdata),
    .cpu_rd_i(cpu_rd), .cpu_rd_word_i(cpu_rd_word), .cpu_rdata_o(cpu_rdata),
    .sts_clr_i(sts_clr), .ovr_o(ovr), .derr_o(derr), .unf_o(unf),
    .stall_req_i(stall_req), .stall_clr_i(stall_clr), .stall_o(stall),
    .bus_rx_valid_i(rx_valid), .bus_rx_data_i(rx_data), .bus_rx_last_i(rx_last),
    .bus_rx_err_i(rx_err), .bus_tx_rd_i(tx_rd), .bus_tx_data_o(tx_data),
    .rx_count_o(rx_count), .rx_free_o(rx_free),
    .tx_count_o(tx_count), .tx_free_o(tx_free)
  );

  int checks = 0, errors = 0;
  logic [15:0] rx_exp[$];
  string       rx_tag[$];
  logic [7:0]  tx_exp[$];
  string       tx_tag[$];
  logic done = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: compares outputs against scoreboard, away from the active edge
  always @(negedge clk) begin
    if (rst_ni && cpu_rd) begin
      if (rx_exp.size() == 0) check("rx-scoreboard-empty", 32'd1, 32'd0);
      else check(rx_tag.pop_front(), {16'h0, cpu_rdata}, {16'h0, rx_exp.pop_front()});
    end
    if (rst_ni && tx_rd) begin
      if (tx_exp.size() == 0) check("tx-scoreboard-empty", 32'd1, 32'd0);
      else check(tx_tag.pop_front(), {24'h0, tx_data}, {24'h0, tx_exp.pop_front()});
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic cpu_write(input logic word, input logic [15:0] d);
    cpu_wr = 1; cpu_wr_word = word; cpu_wdata = d;
    tick();
    cpu_wr = 0;
  endtask

  task automatic cpu_read(input logic word, input logic [15:0] exp, input string tag);
    rx_exp.push_back(exp); rx_tag.push_back(tag);
    cpu_rd = 1; cpu_rd_word = word;
    tick();
    cpu_rd = 0;
  endtask

  task automatic bus_pop(input logic [7:0] exp, input string tag);
    tx_exp.push_back(exp); tx_tag.push_back(tag);
    tx_rd = 1;
    tick();
    tx_rd = 0;
  endtask

  task automatic rx_byte(input logic [7:0] d, input logic last, input logic err);
    rx_valid = 1; rx_data = d; rx_last = last; rx_err = err;
    tick();
    rx_valid = 0; rx_last = 0; rx_err = 0;
  endtask

  task automatic clear(input logic [2:0] m);
    sts_clr = m;
    tick();
    sts_clr = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;
    tick();
    // R1 reset state
    check("R1 rx_count", rx_count, 0);
    check("R1 rx_free", rx_free, DEPTH);
    check("R1 tx_free", tx_free, DEPTH);
    check("R1 flags", {ovr, derr, unf, stall}, 0);

    // R2 byte FIFO order on transmit
    cpu_write(0, 16'h0001); cpu_write(0, 16'h0002); cpu_write(0, 16'h0003);
    check("R7 tx_count", tx_count, 3);
    check("R7 tx_free", tx_free, DEPTH - 3);
    bus_pop(8'h01, "R2 tx byte0"); bus_pop(8'h02, "R2 tx byte1"); bus_pop(8'h03, "R2 tx byte2");

    // R3 little-endian word write
    cfg_wr_le = 1;
    cpu_write(1, 16'hA1B2);
    check("R3 tx_count", tx_count, 2);
    bus_pop(8'hB2, "R3 first"); bus_pop(8'hA1, "R3 second");

    // R4 big-endian word write equals two byte writes high first
    cfg_wr_le = 0;
    cpu_write(1, 16'hA1B2);
    cpu_write(0, 16'h00A1); cpu_write(0, 16'h00B2);
    bus_pop(8'hA1, "R4 word first"); bus_pop(8'hB2, "R4 word second");
    bus_pop(8'hA1, "R4 byte first"); bus_pop(8'hB2, "R4 byte second");

    // R5/R6 word reads
    rx_byte(8'h11, 0, 0); rx_byte(8'h22, 0, 0); rx_byte(8'h33, 0, 0); rx_byte(8'h44, 1, 0);
    check("R7 rx_count", rx_count, 4);
    check("R7 rx_free", rx_free, DEPTH - 4);
    cfg_rd_le = 1; cpu_read(1, 16'h2211, "R5 le word");
    cfg_rd_le = 0; cpu_read(1, 16'h3344, "R6 be word");
    check("R5 rx_count after", rx_count, 0);
    check("R11 no unf on full words", unf, 0);

    // R2 byte read on receive
    rx_byte(8'hAA, 1, 0);
    cpu_read(0, 16'h00AA, "R2 rx byte");

    // R8 packet starting while occupied is dropped
    rx_byte(8'h55, 0, 0); rx_byte(8'h66, 1, 0);
    check("R8 no ovr yet", ovr, 0);
    rx_byte(8'h77, 1, 0);
    check("R8 ovr set", ovr, 1);
    check("R8 count unchanged", rx_count, 2);
    cpu_read(0, 16'h0055, "R8 kept0"); cpu_read(0, 16'h0066, "R8 kept1");
    // R9 clear of other bits leaves ovr, own bit clears it
    clear(3'b110);
    check("R9 ovr kept", ovr, 1);
    clear(3'b001);
    check("R9 ovr cleared", ovr, 0);

    // R8 oversize accepted packet: bytes past full are lost
    for (int i = 0; i <= DEPTH; i++) rx_byte(8'(i), (i == DEPTH), 0);
    check("R8 full count", rx_count, DEPTH);
    check("R8 overflow ovr", ovr, 1);
    for (int i = 0; i < DEPTH; i += 2) cpu_read(1, {8'(i), 8'(i + 1)}, "R8 oversize data");
    clear(3'b001);

    // R10 corrupt packet stored, derr set
    rx_byte(8'h9A, 0, 0); rx_byte(8'hBC, 1, 1);
    check("R10 derr", derr, 1);
    check("R10 stored", rx_count, 2);
    check("R10 no ovr", ovr, 0);
    cfg_rd_le = 1; cpu_read(1, 16'hBC9A, "R10 data");
    clear(3'b010);
    check("R9 derr cleared", derr, 0);

    // R11 underflow
    rx_byte(8'h01, 0, 0); rx_byte(8'h02, 0, 0); rx_byte(8'h03, 1, 0);
    cpu_read(1, 16'h0201, "R11 le full word");
    check("R11 no unf yet", unf, 0);
    cpu_read(1, 16'h0003, "R11 le short word");
    check("R11 unf le", unf, 1);
    check("R11 emptied", rx_count, 0);
    clear(3'b100);
    check("R9 unf cleared", unf, 0);
    rx_byte(8'h04, 1, 0);
    cfg_rd_le = 0; cpu_read(1, 16'h0400, "R11 be short word");
    check("R11 unf be", unf, 1);
    clear(3'b100);
    cpu_read(0, 16'h0000, "R11 empty read");
    check("R11 unf empty", unf, 1);
    check("R11 empty count", rx_count, 0);
    // R9 set wins over clear in same cycle
    sts_clr = 3'b100; cpu_rd = 1; cpu_rd_word = 0;
    rx_exp.push_back(16'h0000); rx_tag.push_back("R11 empty read 2");
    tick(); sts_clr = '0; cpu_rd = 0;
    check("R9 set wins", unf, 1);
    clear(3'b100);

    // R12 stall
    cfg_iso = 0; stall_req = 1; tick(); stall_req = 0;
    check("R12 stall set", stall, 1);
    stall_clr = 1; tick(); stall_clr = 0;
    check("R12 stall clr", stall, 0);
    cfg_iso = 1; stall_req = 1; tick(); stall_req = 0; tick();
    check("R12 iso ignores stall", stall, 0);
    cfg_iso = 0; tick();
    check("R12 iso stays released", stall, 0);

    // R13 writes that do not fit
    for (int i = 0; i < DEPTH - 1; i++) cpu_write(0, 16'(i));
    check("R13 63 stored", tx_count, DEPTH - 1);
    cpu_write(1, 16'hDEAD);
    check("R13 word dropped", tx_count, DEPTH - 1);
    cpu_write(0, 16'h00EE);
    check("R13 last byte", tx_count, DEPTH);
    check("R7 tx_free zero", tx_free, 0);
    cpu_write(0, 16'h00FF);
    check("R13 full dropped", tx_count, DEPTH);
    for (int i = 0; i < DEPTH - 1; i++) bus_pop(8'(i), "R13 drain");
    bus_pop(8'hEE, "R13 tail");
    check("R13 drained", tx_count, 0);

    tick();
    check("R1 rx scoreboard drained", rx_exp.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule